// File: doc/BRIEF.md
# Split-Fetch Miss Handling Unit

This unit tracks last-level cache misses whose line is stored across two memories of different speed. Word 0 of every line lives in a fast, low-latency memory and is guarded by one even-parity bit. Words 1 to 7 live in a slower memory together with a SECDED code that covers the full 64-bit line. Each new miss takes one tracking entry and sends one request to each memory. When the core wants word 0 and that word passes its parity check, the unit forwards it as soon as it arrives. In every other case the unit waits until both parts are back and the line has gone through the error-correction stage, then forwards the wanted word from the corrected line.

The check/correct stage sits outside the block and works combinationally. The unit shows the assembled line and its stored code to that stage. It receives back a corrected line and a flag that marks an error it cannot correct. The cache fill is offered through a valid/ready handshake and always follows the forward of the critical word. A second miss to a line that is already in flight joins the existing entry. When every entry is busy, the unit stops accepting misses.

Top module: `split_fetch_mhu`

## Requirements
- R1: When the unit accepts a miss to a line that is not outstanding, `fast_req_valid` and `slow_req_valid` are both high in the next cycle. In that cycle `mem_req_id` carries the entry number and `mem_req_line` carries the line address. The two valids are never high apart from each other.
- R2: The line is laid out with word k at bits [8k+7:8k]. The fast return is word 0. `slow_rsp_data` holds words 1..7 as line bits [63:8]. `fill_data` and `ecc_chk_line` use the same layout.
- R3: Fast-path parity is even: the word is clean when the XOR of its 8 data bits and its parity bit is 0. If the critical word is word 0 and it returns clean, `fwd_valid` is high in the cycle after the fast return. It carries the raw fast-path data with `fwd_err` low.
- R4: A word 0 that fails parity is not forwarded when it arrives. The forward comes from the corrected line once both parts are present, two cycles after the later of the two returns.
- R5: A critical word in 1..7 is forwarded from `ecc_fix_line` two cycles after the later of the two returns.
- R6: `fill_valid` is offered only when both parts are present and the critical word has been forwarded. `fill_data` is the corrected line. `fill_err` and the `fwd_err` of a late forward both copy `ecc_uncorr`, so an error found on the full line is always flagged.
- R7: While `fill_ready` is low, `fill_valid`, `fill_line_addr` and `fill_data` stay steady. The entry is released at the handshake edge and can be allocated from the next cycle on.
- R8: A miss to a line that already has an entry is absorbed. No memory request goes out, and the line is filled only once.
- R9: `req_ready` is low exactly when every entry is occupied.
- R10: The results (forward data, forward error, fill data, fill error) are the same whichever memory returns first.
- R11: After reset, `req_ready` is high and `fast_req_valid`, `slow_req_valid`, `fwd_valid` and `fill_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Cache miss request |
| req_ready | output | 1 | A free entry exists |
| req_line | input | LINE_ADDR_W | Line address of the miss |
| req_word | input | 3 | Critical word index |
| fast_req_valid | output | 1 | Request to the fast memory (word 0) |
| slow_req_valid | output | 1 | Request to the slow memory (words 1..7 and code) |
| mem_req_id | output | ID_W | Entry number tagging both requests |
| mem_req_line | output | LINE_ADDR_W | Line address for both requests |
| fast_rsp_valid | input | 1 | Fast return beat |
| fast_rsp_id | input | ID_W | Entry of the fast return |
| fast_rsp_data | input | 8 | Word 0 data |
| fast_rsp_par | input | 1 | Even parity bit of word 0 |
| slow_rsp_valid | input | 1 | Slow return beat |
| slow_rsp_id | input | ID_W | Entry of the slow return |
| slow_rsp_data | input | 56 | Words 1..7 |
| slow_rsp_ecc | input | ECC_W | Stored code for the line |
| ecc_chk_line | output | 64 | Line presented for check/correct |
| ecc_chk_code | output | ECC_W | Code presented for check/correct |
| ecc_fix_line | input | 64 | Corrected line |
| ecc_uncorr | input | 1 | Uncorrectable error flag |
| fwd_valid | output | 1 | Critical word forward, one cycle |
| fwd_line | output | LINE_ADDR_W | Line of the forward |
| fwd_word | output | 3 | Word index of the forward |
| fwd_data | output | 8 | Forwarded word |
| fwd_err | output | 1 | Forwarded word comes from an uncorrectable line |
| fill_valid | output | 1 | Cache fill offered |
| fill_ready | input | 1 | Cache takes the fill |
| fill_line_addr | output | LINE_ADDR_W | Line address of the fill |
| fill_data | output | 64 | Corrected line |
| fill_err | output | 1 | Uncorrectable error on the line |

## Verification
Request pulses appear one cycle after the accepting edge. An early forward appears one cycle after the fast return. A late forward appears two cycles after the later return, and the fill is offered in that same cycle, or already one cycle after the later return when the forward was early. The bench drives every input on a falling edge and samples on the falling edge that follows each rising edge it counts. In each vector it checks `fwd_valid` and `fill_valid` in exactly the cycle where they first become due and where they must still be low. A monitor records the payloads of the single forward and the single fill, and the bench compares them after each vector.

// File: rtl/sfm_pkg.sv
// Package: shared helpers for the split-fetch miss handling unit.
// Assumes even parity over one word plus one parity bit.
package sfm_pkg;

    // Selects where a forwarded word comes from.
    typedef enum logic [1:0] {
        FWD_NONE  = 2'd0,
        FWD_EARLY = 2'd1,
        FWD_LATE  = 2'd2
    } fwd_src_e;

    // True when data and parity together hold an even count of ones.
    function automatic logic par_clean(input logic [7:0] d, input logic p);
        return ~(^{d, p});
    endfunction

endpackage

// File: rtl/sfm_first_set.sv
// Module: finds the lowest set bit of a request vector.
// Assumes N >= 2; idx is don't-care when any is low.
module sfm_first_set #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   vec,
    output logic           any,
    output logic [IDW-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/sfm_entry.sv
// Module: one miss tracking entry. It holds the line address, critical word
// index, fast/slow done flags, a forwarded flag and the line buffer.
// Assumes alloc and release are never high together for this entry.
module sfm_entry
    import sfm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 8,
    parameter int WORDS  = 8,
    parameter int ECC_W  = 8,
    parameter int WIDX_W = $clog2(WORDS),
    parameter int LINE_W = WORD_W * WORDS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_i,
    input  logic [ADDR_W-1:0]        alloc_addr_i,
    input  logic [WIDX_W-1:0]        alloc_widx_i,
    input  logic                     fast_hit_i,
    input  logic [WORD_W-1:0]        fast_data_i,
    input  logic                     fast_par_i,
    input  logic                     slow_hit_i,
    input  logic [LINE_W-WORD_W-1:0] slow_data_i,
    input  logic [ECC_W-1:0]         slow_ecc_i,
    input  logic                     late_fwd_i,
    input  logic                     release_i,
    output logic                     valid_o,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [WIDX_W-1:0]        widx_o,
    output logic                     fast_done_o,
    output logic                     slow_done_o,
    output logic                     fwded_o,
    output logic                     early_o,
    output logic [LINE_W-1:0]        line_o,
    output logic [ECC_W-1:0]         ecc_o
);
    // A clean word 0 that is the critical word goes out on arrival.
    always_comb begin
        early_o = valid_o && fast_hit_i && (widx_o == '0)
                  && par_clean(fast_data_i, fast_par_i);
    end

    // Control state: occupancy, done flags and forwarded flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o     <= 1'b0;
            fast_done_o <= 1'b0;
            slow_done_o <= 1'b0;
            fwded_o     <= 1'b0;
            addr_o      <= '0;
            widx_o      <= '0;
        end else if (alloc_i) begin
            valid_o     <= 1'b1;
            fast_done_o <= 1'b0;
            slow_done_o <= 1'b0;
            fwded_o     <= 1'b0;
            addr_o      <= alloc_addr_i;
            widx_o      <= alloc_widx_i;
        end else begin
            if (release_i)  valid_o     <= 1'b0;
            if (fast_hit_i) fast_done_o <= 1'b1;
            if (slow_hit_i) slow_done_o <= 1'b1;
            if (early_o || late_fwd_i) fwded_o <= 1'b1;
        end
    end

    // Line buffer: word 0 from the fast path, the rest and the code from the slow path.
    always_ff @(posedge clk) begin
        if (fast_hit_i) line_o[WORD_W-1:0] <= fast_data_i;
        if (slow_hit_i) begin
            line_o[LINE_W-1:WORD_W] <= slow_data_i;
            ecc_o                   <= slow_ecc_i;
        end
    end
endmodule

// File: rtl/split_fetch_mhu.sv
// Module: split-fetch miss handling unit (top). It allocates entries, sends
// one request to each memory, forwards the critical word early or after
// correction, and offers the corrected line as a fill.
// Assumes the return ids name live entries and the check/correct stage is combinational.
module split_fetch_mhu
    import sfm_pkg::*;
#(
    parameter int LINE_ADDR_W = 16,
    parameter int WORD_W      = 8,
    parameter int LINE_WORDS  = 8,
    parameter int ECC_W       = 8,
    parameter int ENTRIES     = 4,
    localparam int ID_W       = $clog2(ENTRIES),
    localparam int WIDX_W     = $clog2(LINE_WORDS),
    localparam int LINE_W     = WORD_W * LINE_WORDS,
    localparam int SLOW_W     = LINE_W - WORD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [LINE_ADDR_W-1:0] req_line,
    input  logic [WIDX_W-1:0]      req_word,
    output logic                   fast_req_valid,
    output logic                   slow_req_valid,
    output logic [ID_W-1:0]        mem_req_id,
    output logic [LINE_ADDR_W-1:0] mem_req_line,
    input  logic                   fast_rsp_valid,
    input  logic [ID_W-1:0]        fast_rsp_id,
    input  logic [WORD_W-1:0]      fast_rsp_data,
    input  logic                   fast_rsp_par,
    input  logic                   slow_rsp_valid,
    input  logic [ID_W-1:0]        slow_rsp_id,
    input  logic [SLOW_W-1:0]      slow_rsp_data,
    input  logic [ECC_W-1:0]       slow_rsp_ecc,
    output logic [LINE_W-1:0]      ecc_chk_line,
    output logic [ECC_W-1:0]       ecc_chk_code,
    input  logic [LINE_W-1:0]      ecc_fix_line,
    input  logic                   ecc_uncorr,
    output logic                   fwd_valid,
    output logic [LINE_ADDR_W-1:0] fwd_line,
    output logic [WIDX_W-1:0]      fwd_word,
    output logic [WORD_W-1:0]      fwd_data,
    output logic                   fwd_err,
    output logic                   fill_valid,
    input  logic                   fill_ready,
    output logic [LINE_ADDR_W-1:0] fill_line_addr,
    output logic [LINE_W-1:0]      fill_data,
    output logic                   fill_err
);
    logic [ENTRIES-1:0] ent_valid, ent_fdone, ent_sdone, ent_fwded, ent_early;
    logic [ENTRIES-1:0] ent_alloc, ent_late, ent_rel, match_vec, cmpl_vec;
    logic [LINE_ADDR_W-1:0] ent_addr [ENTRIES];
    logic [WIDX_W-1:0]      ent_widx [ENTRIES];
    logic [LINE_W-1:0]      ent_line [ENTRIES];
    logic [ECC_W-1:0]       ent_ecc  [ENTRIES];

    logic            free_any, cmpl_any, accept, is_new, early_any, hold_q;
    logic [ID_W-1:0] free_idx, cmpl_idx, sel_idx, hold_idx;
    logic            fill_fire;
    fwd_src_e        fwd_src;

    // Pick the lowest free entry for a new miss.
    sfm_first_set #(.N(ENTRIES), .IDW(ID_W)) u_free (
        .vec(~ent_valid), .any(free_any), .idx(free_idx));

    // Pick the lowest entry that holds a complete line.
    sfm_first_set #(.N(ENTRIES), .IDW(ID_W)) u_cmpl (
        .vec(cmpl_vec), .any(cmpl_any), .idx(cmpl_idx));

    // One tracking entry per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        sfm_entry #(.ADDR_W(LINE_ADDR_W), .WORD_W(WORD_W), .WORDS(LINE_WORDS),
                    .ECC_W(ECC_W)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(ent_alloc[g]), .alloc_addr_i(req_line), .alloc_widx_i(req_word),
            .fast_hit_i(fast_rsp_valid && fast_rsp_id == ID_W'(g)),
            .fast_data_i(fast_rsp_data), .fast_par_i(fast_rsp_par),
            .slow_hit_i(slow_rsp_valid && slow_rsp_id == ID_W'(g)),
            .slow_data_i(slow_rsp_data), .slow_ecc_i(slow_rsp_ecc),
            .late_fwd_i(ent_late[g]), .release_i(ent_rel[g]),
            .valid_o(ent_valid[g]), .addr_o(ent_addr[g]), .widx_o(ent_widx[g]),
            .fast_done_o(ent_fdone[g]), .slow_done_o(ent_sdone[g]),
            .fwded_o(ent_fwded[g]), .early_o(ent_early[g]),
            .line_o(ent_line[g]), .ecc_o(ent_ecc[g]));
    end

    // Request side: line match (ignoring the entry that leaves now) and allocation.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            match_vec[i] = ent_valid[i] && !ent_rel[i] && (ent_addr[i] == req_line);
            cmpl_vec[i]  = ent_valid[i] && ent_fdone[i] && ent_sdone[i];
        end
        req_ready = free_any;
        accept    = req_valid && req_ready;
        is_new    = accept && !(|match_vec);
        ent_alloc = is_new ? (ENTRIES'(1) << free_idx) : '0;
    end

    // Completion side: locked selection, codec hookup, forward choice, fill.
    always_comb begin
        sel_idx        = hold_q ? hold_idx : cmpl_idx;
        ecc_chk_line   = ent_line[sel_idx];
        ecc_chk_code   = ent_ecc[sel_idx];
        early_any      = |ent_early;
        fill_valid     = (hold_q || cmpl_any) && ent_fwded[sel_idx];
        fill_line_addr = ent_addr[sel_idx];
        fill_data      = ecc_fix_line;
        fill_err       = ecc_uncorr;
        fill_fire      = fill_valid && fill_ready;
        ent_rel        = fill_fire ? (ENTRIES'(1) << sel_idx) : '0;
        if (early_any)
            fwd_src = FWD_EARLY;
        else if (cmpl_any && !hold_q && !ent_fwded[sel_idx])
            fwd_src = FWD_LATE;
        else
            fwd_src = FWD_NONE;
        ent_late = (fwd_src == FWD_LATE) ? (ENTRIES'(1) << sel_idx) : '0;
    end

    // Keep the offered fill fixed until the cache takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= 1'b0;
            hold_idx <= '0;
        end else begin
            hold_q   <= fill_valid && !fill_ready;
            hold_idx <= sel_idx;
        end
    end

    // Memory requests: one pulse to each path per new miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_req_valid <= 1'b0;
            slow_req_valid <= 1'b0;
            mem_req_id     <= '0;
            mem_req_line   <= '0;
        end else begin
            fast_req_valid <= is_new;
            slow_req_valid <= is_new;
            if (is_new) begin
                mem_req_id   <= free_idx;
                mem_req_line <= req_line;
            end
        end
    end

    // Forward register: early raw word or late corrected word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_line  <= '0;
            fwd_word  <= '0;
            fwd_data  <= '0;
            fwd_err   <= 1'b0;
        end else begin
            fwd_valid <= (fwd_src != FWD_NONE);
            if (fwd_src == FWD_EARLY) begin
                fwd_line <= ent_addr[fast_rsp_id];
                fwd_word <= '0;
                fwd_data <= fast_rsp_data;
                fwd_err  <= 1'b0;
            end else if (fwd_src == FWD_LATE) begin
                fwd_line <= ent_addr[sel_idx];
                fwd_word <= ent_widx[sel_idx];
                fwd_data <= ecc_fix_line[ent_widx[sel_idx]*WORD_W +: WORD_W];
                fwd_err  <= ecc_uncorr;
            end
        end
    end
endmodule

// File: rtl/sfm_chk.sv
// Module: assertion checker for split_fetch_mhu, attached with bind.
// Assumes it sees the entry flag vectors and the selected entry of the top.
module sfm_chk #(
    parameter int ENTRIES = 4,
    parameter int ID_W    = 2,
    parameter int ADDR_W  = 16,
    parameter int LINE_W  = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               fast_req_valid,
    input logic               slow_req_valid,
    input logic               fill_valid,
    input logic               fill_ready,
    input logic [ADDR_W-1:0]  fill_line_addr,
    input logic [LINE_W-1:0]  fill_data,
    input logic [ENTRIES-1:0] ent_valid,
    input logic [ENTRIES-1:0] ent_fdone,
    input logic [ENTRIES-1:0] ent_sdone,
    input logic [ENTRIES-1:0] ent_fwded,
    input logic [ID_W-1:0]    sel_idx
);
    a_r1_paired_fast: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req_valid |-> slow_req_valid);
    a_r1_paired_slow: assert property (@(posedge clk) disable iff (!rst_n)
        slow_req_valid |-> fast_req_valid);
    a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (&ent_valid) |-> !req_ready);
    a_r9_room_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        !(&ent_valid) |-> req_ready);
    a_r6_fill_complete: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (ent_valid[sel_idx] && ent_fdone[sel_idx]
                        && ent_sdone[sel_idx] && ent_fwded[sel_idx]));
    a_r7_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_line_addr)
                                         && $stable(fill_data)));
    a_r7_fill_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_ready) |=> !ent_valid[$past(sel_idx)]);
endmodule

bind split_fetch_mhu sfm_chk #(
    .ENTRIES(ENTRIES), .ID_W(ID_W), .ADDR_W(LINE_ADDR_W), .LINE_W(LINE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .fast_req_valid(fast_req_valid), .slow_req_valid(slow_req_valid),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_line_addr(fill_line_addr), .fill_data(fill_data),
    .ent_valid(ent_valid), .ent_fdone(ent_fdone), .ent_sdone(ent_sdone),
    .ent_fwded(ent_fwded), .sel_idx(sel_idx)
);

// File: tb/split_fetch_mhu_tb_top.sv
// Bench: a vector table walked by one loop, then directed reset, merge,
// full and fill-backpressure tests. Also models a toy check/correct stage.
module split_fetch_mhu_tb_top;
    localparam int AW = 16, WW = 8, NW = 8, EW = 8, NE = 4;
    localparam int IDW = $clog2(NE), LW = WW * NW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_line = '0;
    logic [2:0] req_word = '0;
    logic fast_req_valid, slow_req_valid;
    logic [IDW-1:0] mem_req_id;
    logic [AW-1:0] mem_req_line;
    logic fast_rsp_valid = 1'b0, fast_rsp_par = 1'b0;
    logic [IDW-1:0] fast_rsp_id = '0, slow_rsp_id = '0;
    logic [WW-1:0] fast_rsp_data = '0;
    logic slow_rsp_valid = 1'b0;
    logic [LW-WW-1:0] slow_rsp_data = '0;
    logic [EW-1:0] slow_rsp_ecc = '0;
    logic [LW-1:0] ecc_chk_line, ecc_fix_line;
    logic [EW-1:0] ecc_chk_code;
    logic ecc_uncorr;
    logic fwd_valid, fwd_err, fill_valid, fill_err;
    logic fill_ready = 1'b1;
    logic [AW-1:0] fwd_line, fill_line_addr;
    logic [2:0] fwd_word;
    logic [WW-1:0] fwd_data;
    logic [LW-1:0] fill_data;

    always #4 clk = ~clk;

    split_fetch_mhu dut_i (.*);

    // Toy codec: syndrome = XOR of all words ^ code; one set bit is fixed in
    // word 0, two or more set bits mark the line uncorrectable.
    logic [WW-1:0] syn;
    always_comb begin
        syn = ecc_chk_code;
        for (int k = 0; k < NW; k++) syn ^= ecc_chk_line[k*WW +: WW];
        ecc_uncorr   = ($countones(syn) >= 2);
        ecc_fix_line = ecc_chk_line;
        if (!ecc_uncorr) ecc_fix_line[WW-1:0] = ecc_chk_line[WW-1:0] ^ syn;
    end

    int checks = 0, fails = 0;
    int fwd_cnt = 0, fill_cnt = 0, fill_a0_cnt = 0;
    logic [WW-1:0] cap_fwd_data;
    logic cap_fwd_err, cap_fill_err;
    logic [LW-1:0] cap_fill_data;
    logic [AW-1:0] cap_fwd_line, cap_fill_addr;

    // Monitor: record forwards and taken fills.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fwd_valid) begin
                fwd_cnt++; cap_fwd_data = fwd_data; cap_fwd_err = fwd_err;
                cap_fwd_line = fwd_line;
            end
            if (fill_valid && fill_ready) begin
                fill_cnt++; cap_fill_data = fill_data; cap_fill_err = fill_err;
                cap_fill_addr = fill_line_addr;
                if (fill_line_addr == 16'h2000) fill_a0_cnt++;
            end
        end
    end

    task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] mk_line(input logic [7:0] seed);
        logic [LW-1:0] l;
        for (int k = 0; k < NW; k++) l[k*WW +: WW] = seed + 8'(k) * 8'h17;
        return l;
    endfunction

    function automatic logic [EW-1:0] mk_code(input logic [LW-1:0] l);
        logic [EW-1:0] c = '0;
        for (int k = 0; k < NW; k++) c ^= l[k*WW +: WW];
        return c;
    endfunction

    task automatic send_req(input logic [AW-1:0] a, input logic [2:0] w);
        @(negedge clk); req_valid = 1'b1; req_line = a; req_word = w;
        @(posedge clk); @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic send_fast(input logic [IDW-1:0] id, input logic [WW-1:0] d, input logic p);
        fast_rsp_valid = 1'b1; fast_rsp_id = id; fast_rsp_data = d; fast_rsp_par = p;
        @(posedge clk); @(negedge clk); fast_rsp_valid = 1'b0;
    endtask

    task automatic send_slow(input logic [IDW-1:0] id, input logic [LW-1:0] l);
        slow_rsp_valid = 1'b1; slow_rsp_id = id; slow_rsp_data = l[LW-1:WW];
        slow_rsp_ecc = mk_code(l);
        @(posedge clk); @(negedge clk); slow_rsp_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [2:0] crit; logic [7:0] seed; logic [7:0] flip;
        logic slow_first; logic exp_early; logic exp_bad;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{3'd0, 8'h11, 8'h00, 1'b0, 1'b1, 1'b0},
        '{3'd0, 8'h22, 8'h00, 1'b1, 1'b1, 1'b0},
        '{3'd0, 8'h33, 8'h04, 1'b0, 1'b0, 1'b0},
        '{3'd0, 8'h44, 8'h80, 1'b1, 1'b0, 1'b0},
        '{3'd5, 8'h55, 8'h00, 1'b0, 1'b0, 1'b0},
        '{3'd7, 8'h66, 8'h00, 1'b1, 1'b0, 1'b0},
        '{3'd3, 8'h77, 8'h01, 1'b0, 1'b0, 1'b0},
        '{3'd0, 8'h88, 8'h03, 1'b0, 1'b1, 1'b1},
        '{3'd2, 8'h99, 8'h18, 1'b1, 1'b0, 1'b1},
        '{3'd1, 8'hAA, 8'h00, 1'b0, 1'b0, 1'b0}
    };

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [IDW-1:0] ids [4];
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11 ready", LW'(req_ready), 1);
        check("R11 reqs", LW'({fast_req_valid, slow_req_valid}), 0);
        check("R11 fwd/fill", LW'({fwd_valid, fill_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 10; v++) begin
            vec_t t = VECS[v];
            logic [LW-1:0] tl = mk_line(t.seed);
            logic [IDW-1:0] id;
            logic [LW-1:0] efill;
            logic [WW-1:0] efwd;
            fwd_cnt = 0; fill_cnt = 0;
            send_req(16'h1000 + AW'(v), t.crit);
            // R1: both requests one cycle after accept
            check("R1 split", LW'({fast_req_valid, slow_req_valid}), 2'b11);
            check("R1 line", LW'(mem_req_line), LW'(16'h1000 + AW'(v)));
            id = mem_req_id;
            if (t.slow_first) send_slow(id, tl);
            send_fast(id, tl[WW-1:0] ^ t.flip, ^tl[WW-1:0]);
            // R3/R4: early forward exactly one cycle after a clean word-0 return
            check("R3 R4 early fwd timing", LW'(fwd_valid), LW'(t.exp_early));
            if (!t.slow_first) send_slow(id, tl);
            // R6: fill offered one cycle after completion only if already forwarded
            check("R6 fill after fwd", LW'(fill_valid), LW'(t.exp_early));
            if (!t.exp_early) begin
                check("R4 R5 no fwd yet", LW'(fwd_valid), 0);
                @(negedge clk);
                check("R4 R5 late fwd timing", LW'(fwd_valid), 1);
                check("R6 fill with late fwd", LW'(fill_valid), 1);
            end
            repeat (3) @(negedge clk);
            efwd  = (t.exp_early && t.flip != 0) ? (tl[WW-1:0] ^ t.flip)
                                                 : tl[t.crit*WW +: WW];
            efill = t.exp_bad ? {tl[LW-1:WW], tl[WW-1:0] ^ t.flip} : tl;
            // R10: vectors pair both return orders with the same expectations
            check("R3 R4 R5 R10 fwd data", LW'(cap_fwd_data), LW'(efwd));
            check("R6 fwd err", LW'(cap_fwd_err), LW'(t.exp_bad && !t.exp_early));
            check("R2 R10 fill data", cap_fill_data, efill);
            check("R6 fill err", LW'(cap_fill_err), LW'(t.exp_bad));
            check("R7 one fwd one fill", LW'({fwd_cnt[3:0], fill_cnt[3:0]}), 8'h11);
        end

        // R8: merge into an outstanding line
        fill_cnt = 0; fill_a0_cnt = 0;
        send_req(16'h2000, 3'd0); ids[0] = mem_req_id;
        send_req(16'h2000, 3'd3);
        check("R8 no new request", LW'({fast_req_valid, slow_req_valid}), 0);
        for (int j = 1; j < 4; j++) begin
            send_req(16'h2000 + AW'(j), 3'd0); ids[j] = mem_req_id;
        end
        // R9: all entries busy
        check("R9 full not ready", LW'(req_ready), 0);
        fill_ready = 1'b0;
        send_fast(ids[1], mk_line(8'h31)[WW-1:0], ^mk_line(8'h31)[WW-1:0]);
        send_slow(ids[1], mk_line(8'h31));
        repeat (3) @(negedge clk);
        // R7: fill held under backpressure
        check("R7 hold valid", LW'(fill_valid), 1);
        check("R7 hold addr", LW'(fill_line_addr), LW'(16'h2001));
        check("R7 hold data", fill_data, mk_line(8'h31));
        check("R9 still full", LW'(req_ready), 0);
        fill_ready = 1'b1;
        @(negedge clk);
        check("R7 R9 freed after fill", LW'(req_ready), 1);
        for (int j = 0; j < 4; j++) begin
            if (j != 1) begin
                send_fast(ids[j], mk_line(8'h40)[WW-1:0], ^mk_line(8'h40)[WW-1:0]);
                send_slow(ids[j], mk_line(8'h40));
            end
        end
        repeat (4) @(negedge clk);
        check("R8 merged line filled once", LW'(fill_a0_cnt), 1);
        check("R8 fills total", LW'(fill_cnt), 4);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule